// File: doc/BRIEF.md
# Floating-Point Dependency and Unit-Busy Scoreboard

This block sits beside the issue logic of a floating-point pipeline. It answers one question every cycle: may the consumer being considered issue now? To answer it, the block tracks when each floating-point register's pending result becomes usable. It also tracks how long the divide and square-root units stay occupied.

The producer side presents the following, and the block refuses a divide or square root whose unit is still occupied:
- a destination register,
- an operation class,
- a precision bit.

The consumer side presents two source registers and a consumer kind. Ordinary consumers see a shorter wait than stores and float-to-integer moves.

Each register holds two countdowns, one for each consumer group. The countdowns are loaded when the producer issues and run down to zero. A producer that issues in the same cycle as a check on its destination is already visible to that check.

Top module: `fsb_scoreboard`

## Requirements
- R1: After reset the block reports every register free, for every consumer kind, and accepts a divide or square root.
- R2: Add (`prod_op`=1) and multiply (`prod_op`=2) results are usable 4 cycles after issue by a general consumer (`cons_kind`=0). A store (`cons_kind`=1) or float-to-integer consumer (`cons_kind`=2) must wait 6 cycles.
- R3: Conditional-move first half (`prod_op`=3) blocks its destination for 4 cycles for every consumer kind. The second half (`prod_op`=4) gives 4 cycles to general consumers and 6 to store or float-to-integer consumers.
- R4: Divide (`prod_op`=5) results are usable after 12 cycles in single precision (`prod_dbl`=0) and 15 cycles in double precision (`prod_dbl`=1), for every consumer kind.
- R5: Square-root (`prod_op`=6) results are usable after 18 cycles single and 33 cycles double, for every consumer kind.
- R6: After a divide issues, `prod_allow` is low for another divide until 9 (single) or 12 (double) cycles have passed. After a square root issues, the same holds for another square root until 15 or 30 cycles have passed. Other classes are never refused.
- R7: Integer-to-float move (`prod_op`=8) blocks its destination for 4 cycles. Nop (`prod_op`=0) and float-to-integer move (`prod_op`=7) leave every register free.
- R8: A check in the same cycle as a producer issue, on that producer's destination, reports not allowed.
- R9: `cons_allow` is low when either source is pending for the given consumer kind. Otherwise it is high. Registers are tracked independently.
- R10: A divide or square root presented while `prod_allow` is low leaves no pending register and does not restart its unit's busy time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prod_valid | input | 1 | Producer issue request |
| prod_dst | input | 5 | Producer destination register |
| prod_op | input | 4 | Operation class: 0 nop, 1 add, 2 mul, 3 cmov first, 4 cmov second, 5 div, 6 sqrt, 7 float-to-int, 8 int-to-float |
| prod_dbl | input | 1 | 1 selects double precision |
| prod_allow | output | 1 | Producer may issue (unit free) |
| cons_src_a | input | 5 | First consumer source register |
| cons_src_b | input | 5 | Second consumer source register |
| cons_kind | input | 2 | 0 general, 1 store, 2 float-to-int move |
| cons_allow | output | 1 | Consumer may issue this cycle |

## Verification
The bench sweeps every class, precision and consumer kind and checks the exact cycle at which the destination frees. An off-by-one counter load would free a register one cycle early or late. Mixing up the two consumer groups would show as a store freed at 4 cycles.

Unit reuse is swept separately. A refused divide is injected mid-busy: a design that let that request load state would leave a pending register behind or stretch the busy window. The same-cycle check and a walk over all 32 registers through both source ports catch a missing bypass and crossed register decoding.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_MUL   = 4'd2,
    OP_CMV1  = 4'd3,
    OP_CMV2  = 4'd4,
    OP_DIV   = 4'd5,
    OP_SQRT  = 4'd6,
    OP_FTOI  = 4'd7,
    OP_ITOF  = 4'd8
  } fop_e;

  typedef enum logic [1:0] {
    CK_GEN   = 2'd0,
    CK_STORE = 2'd1,
    CK_F2I   = 2'd2
  } ckind_e;

  // whether the class writes a floating-point register at all
  function automatic logic writes_fp(fop_e op);
    return !(op == OP_NOP || op == OP_FTOI ||
             op == OP_CMV1 && 1'b0) && (op <= OP_ITOF);
  endfunction

  // cycles from issue until a consumer of the given group may issue
  function automatic int res_lat(fop_e op, logic dbl, logic slow);
    case (op)
      OP_ADD, OP_MUL, OP_CMV2: return slow ? 6 : 4;
      OP_CMV1:                 return 4;
      OP_DIV:                  return dbl ? 15 : 12;
      OP_SQRT:                 return dbl ? 33 : 18;
      OP_ITOF:                 return 4;
      default:                 return 0;
    endcase
  endfunction

  // cycles from issue until the same unit may accept again
  function automatic int unit_lat(fop_e op, logic dbl);
    case (op)
      OP_DIV:  return dbl ? 12 : 9;
      OP_SQRT: return dbl ? 30 : 15;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/fsb_countdown.sv
module fsb_countdown #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end
  assign busy = (cnt != '0);
endmodule

// File: rtl/fsb_src_check.sv
module fsb_src_check #(
  parameter int NREG = 32,
  parameter int AW   = 5
) (
  input  logic [NREG-1:0] gen_busy,
  input  logic [NREG-1:0] st_busy,
  input  logic [AW-1:0]   src,
  input  logic            slow,
  input  logic            fp_write,
  input  logic [AW-1:0]   dst,
  output logic            blocked
);
  logic hit_new;
  assign hit_new = fp_write && (dst == src);
  assign blocked = hit_new || (slow ? st_busy[src] : gen_busy[src]);
endmodule

// File: rtl/fsb_scoreboard.sv
module fsb_scoreboard
  import fsb_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int MAX_LAT = 33
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prod_valid,
  input  logic [4:0] prod_dst,
  input  logic [3:0] prod_op,
  input  logic       prod_dbl,
  output logic       prod_allow,
  input  logic [4:0] cons_src_a,
  input  logic [4:0] cons_src_b,
  input  logic [1:0] cons_kind,
  output logic       cons_allow
);
  localparam int AW = $clog2(NREG);
  localparam int CW = $clog2(MAX_LAT + 1);

  fop_e          op;
  logic          unit_conflict;
  logic          issue_fire;
  logic          fp_write;
  logic          slow;
  logic [CW-1:0] gen_ld_val, st_ld_val, unit_ld_val;
  logic [CW-1:0] div_cnt, sqrt_cnt;
  logic          div_busy, sqrt_busy;
  logic [NREG-1:0] gen_busy, st_busy;
  logic          blk_a, blk_b;

  assign op            = fop_e'(prod_op);
  assign unit_conflict = (op == OP_DIV && div_busy) || (op == OP_SQRT && sqrt_busy);
  assign prod_allow    = !unit_conflict;
  assign issue_fire    = prod_valid && prod_allow;
  assign fp_write      = issue_fire && writes_fp(op);
  assign slow          = (cons_kind != CK_GEN);

  assign gen_ld_val  = CW'(res_lat(op, prod_dbl, 1'b0) - 1);
  assign st_ld_val   = CW'(res_lat(op, prod_dbl, 1'b1) - 1);
  assign unit_ld_val = CW'(unit_lat(op, prod_dbl) - 1);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic          ld;
    logic [CW-1:0] gcnt, scnt;
    assign ld = fp_write && (prod_dst[AW-1:0] == AW'(i));
    fsb_countdown #(.CW(CW)) u_gen (
      .clk(clk), .rst_n(rst_n), .load(ld), .load_val(gen_ld_val),
      .cnt(gcnt), .busy(gen_busy[i]));
    fsb_countdown #(.CW(CW)) u_st (
      .clk(clk), .rst_n(rst_n), .load(ld), .load_val(st_ld_val),
      .cnt(scnt), .busy(st_busy[i]));
  end

  fsb_countdown #(.CW(CW)) u_div (
    .clk(clk), .rst_n(rst_n), .load(issue_fire && op == OP_DIV),
    .load_val(unit_ld_val), .cnt(div_cnt), .busy(div_busy));
  fsb_countdown #(.CW(CW)) u_sqrt (
    .clk(clk), .rst_n(rst_n), .load(issue_fire && op == OP_SQRT),
    .load_val(unit_ld_val), .cnt(sqrt_cnt), .busy(sqrt_busy));

  fsb_src_check #(.NREG(NREG), .AW(AW)) u_chk_a (
    .gen_busy(gen_busy), .st_busy(st_busy), .src(cons_src_a[AW-1:0]),
    .slow(slow), .fp_write(fp_write), .dst(prod_dst[AW-1:0]), .blocked(blk_a));
  fsb_src_check #(.NREG(NREG), .AW(AW)) u_chk_b (
    .gen_busy(gen_busy), .st_busy(st_busy), .src(cons_src_b[AW-1:0]),
    .slow(slow), .fp_write(fp_write), .dst(prod_dst[AW-1:0]), .blocked(blk_b));

  assign cons_allow = !(blk_a || blk_b);
endmodule

// File: rtl/fsb_checker.sv
module fsb_checker #(
  parameter int NREG = 32,
  parameter int CW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      prod_op,
  input logic [4:0]      prod_dst,
  input logic [4:0]      cons_src_a,
  input logic            cons_allow,
  input logic            issue_fire,
  input logic            fp_write,
  input logic [CW-1:0]   div_cnt,
  input logic [CW-1:0]   sqrt_cnt,
  input logic [NREG-1:0] gen_busy,
  input logic [NREG-1:0] st_busy
);
  AST_DIV_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (div_cnt != '0) |-> !(issue_fire && prod_op == 4'd5)); // R6
  AST_SQRT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (sqrt_cnt != '0) |-> !(issue_fire && prod_op == 4'd6)); // R6
  AST_BUSY_RUNS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (div_cnt != '0) |=> (div_cnt == $past(div_cnt) - 1'b1)); // R10
  AST_SAME_CYCLE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_write && prod_dst == cons_src_a) |-> !cons_allow); // R8
  AST_STORE_COVERS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((gen_busy & ~st_busy) == '0)); // R2
  AST_IDLE_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_busy == '0 && st_busy == '0 && !fp_write) |-> cons_allow); // R9
endmodule

bind fsb_scoreboard fsb_checker #(.NREG(NREG), .CW(CW)) u_fsb_checker (
  .clk(clk), .rst_n(rst_n), .prod_op(prod_op), .prod_dst(prod_dst),
  .cons_src_a(cons_src_a), .cons_allow(cons_allow), .issue_fire(issue_fire),
  .fp_write(fp_write), .div_cnt(div_cnt), .sqrt_cnt(sqrt_cnt),
  .gen_busy(gen_busy), .st_busy(st_busy));

// File: tb/tb_fsb_scoreboard.sv
module tb_fsb_scoreboard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prod_valid = 1'b0;
  logic [4:0] prod_dst = '0;
  logic [3:0] prod_op = '0;
  logic       prod_dbl = 1'b0;
  logic       prod_allow;
  logic [4:0] cons_src_a = '0;
  logic [4:0] cons_src_b = '0;
  logic [1:0] cons_kind = '0;
  logic       cons_allow;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  fsb_scoreboard dut (
    .clk(clk), .rst_n(rst_n), .prod_valid(prod_valid), .prod_dst(prod_dst),
    .prod_op(prod_op), .prod_dbl(prod_dbl), .prod_allow(prod_allow),
    .cons_src_a(cons_src_a), .cons_src_b(cons_src_b), .cons_kind(cons_kind),
    .cons_allow(cons_allow));

  // unit reuse: divide 9 + 3 per precision step, sqrt 15 doubled
  function automatic int e_unit(int op, int dbl);
    if (op == 5) return 9 + 3 * dbl;
    if (op == 6) return 15 + 15 * dbl;
    return 0;
  endfunction

  // result wait: divide/sqrt are reuse + 3; short classes 4, +2 for slow consumers
  function automatic int e_res(int op, int dbl, int kind);
    if (op == 5 || op == 6) return e_unit(op, dbl) + 3;
    if (op == 1 || op == 2 || op == 4) return 4 + ((kind != 0) ? 2 : 0);
    if (op == 3 || op == 8) return 4;
    return 0;
  endfunction

  function automatic string tag_of(int op);
    case (op)
      1, 2:    return "R2";
      3, 4:    return "R3";
      5:       return "R4";
      6:       return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      prod_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int r = 0; r < 32; r++) begin
      for (int k = 0; k < 3; k++) begin
        cons_src_a = 5'(r); cons_src_b = 5'(31 - r); cons_kind = 2'(k);
        #1 chk(cons_allow, 1'b1, "R1", "reset reg free");
      end
    end
    prod_op = 4'd5; #1 chk(prod_allow, 1'b1, "R1", "div accepted after reset");
    prod_op = 4'd6; #1 chk(prod_allow, 1'b1, "R1", "sqrt accepted after reset");

    // class x precision x consumer sweep: R2 R3 R4 R5 R7 R8
    for (int op = 0; op < 9; op++) begin
      for (int dbl = 0; dbl < 2; dbl++) begin
        for (int kind = 0; kind < 3; kind++) begin
          automatic int r = (op * 7 + dbl * 3 + kind * 11) % 32;
          automatic int lat = e_res(op, dbl, kind);
          @(negedge clk);
          prod_valid = 1'b1; prod_op = 4'(op); prod_dbl = dbl[0];
          prod_dst = 5'(r); cons_src_a = 5'(r); cons_src_b = 5'((r + 1) % 32);
          cons_kind = 2'(kind);
          #1 chk(cons_allow, (lat == 0), "R8", $sformatf("same cycle op=%0d", op));
          for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            prod_valid = 1'b0;
            #1 chk(cons_allow, (k >= lat), tag_of(op),
                   $sformatf("op=%0d dbl=%0d kind=%0d k=%0d", op, dbl, kind, k));
          end
        end
      end
    end

    // R6: unit reuse windows
    for (int op = 5; op < 7; op++) begin
      for (int dbl = 0; dbl < 2; dbl++) begin
        automatic int u = e_unit(op, dbl);
        @(negedge clk);
        prod_valid = 1'b1; prod_op = 4'(op); prod_dbl = dbl[0]; prod_dst = 5'd20;
        for (int k = 1; k <= 35; k++) begin
          @(negedge clk);
          prod_valid = 1'b0; prod_op = 4'(op);
          #1 chk(prod_allow, (k >= u), "R6", $sformatf("reuse op=%0d dbl=%0d k=%0d", op, dbl, k));
          if (k == 1) begin
            prod_op = 4'd1;
            #1 chk(prod_allow, 1'b1, "R6", "add not refused while unit busy");
            prod_op = 4'(11 - op);
            #1 chk(prod_allow, 1'b1, "R6", "other unit still free");
            prod_op = 4'(op);
          end
        end
      end
    end
    idle(40);

    // R10: refused divide leaves nothing behind
    @(negedge clk);
    prod_valid = 1'b1; prod_op = 4'd5; prod_dbl = 1'b0; prod_dst = 5'd3;
    @(negedge clk); prod_valid = 1'b0;
    @(negedge clk);
    prod_valid = 1'b1; prod_op = 4'd5; prod_dbl = 1'b1; prod_dst = 5'd9;
    cons_src_a = 5'd9; cons_src_b = 5'd9; cons_kind = 2'd0;
    #1 chk(prod_allow, 1'b0, "R10", "second divide refused");
    #1 chk(cons_allow, 1'b1, "R10", "refused divide not seen same cycle");
    for (int k = 3; k <= 10; k++) begin
      @(negedge clk);
      prod_valid = 1'b0; prod_op = 4'd5;
      #1 chk(cons_allow, 1'b1, "R10", $sformatf("refused dst free k=%0d", k));
      #1 chk(prod_allow, (k >= 9), "R10", $sformatf("busy not restarted k=%0d", k));
    end
    idle(20);

    // R9: each register through each source port
    for (int r = 0; r < 32; r++) begin
      @(negedge clk);
      prod_valid = 1'b1; prod_op = 4'd1; prod_dbl = 1'b0; prod_dst = 5'(r);
      @(negedge clk);
      prod_valid = 1'b0; cons_kind = 2'd0;
      cons_src_a = 5'((r + 5) % 32); cons_src_b = 5'(r);
      #1 chk(cons_allow, 1'b0, "R9", $sformatf("src_b pending r=%0d", r));
      cons_src_a = 5'(r); cons_src_b = 5'((r + 9) % 32);
      #1 chk(cons_allow, 1'b0, "R9", $sformatf("src_a pending r=%0d", r));
      cons_src_a = 5'((r + 1) % 32); cons_src_b = 5'((r + 31) % 32);
      #1 chk(cons_allow, 1'b1, "R9", $sformatf("neighbours free r=%0d", r));
      idle(6);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule